// File: doc/BRIEF.md
# Two-Level Snapshot Fairness Bus Arbiter

This block grants a shared secondary bus to one agent at a time. Six external masters and the bridge's own master each drive a request and receive a grant. Each agent carries a priority bit (high level or low level) and a mask bit; a masked agent is never granted. A single enable pin turns the whole arbiter on or off. A done input marks the end of the current bus tenure, and the arbiter makes its next decision only on such a boundary, or when the bus is idle or parked.

Fairness works on frozen snapshots of the pending requests at each level. The arbiter serves every agent in a high-level snapshot in rotating order. It then serves exactly one agent from the low-level snapshot. After that it captures a new high-level snapshot. The low-level snapshot is only recaptured once every agent in it has been served, so low-priority agents rotate fairly while high-priority traffic keeps going. When nothing is eligible, the grant parks on the bridge, provided the bridge is not masked.

Top module: `snapfair_arb`

## Requirements
- R1: At most one grant output, across `ext_gnt` and `brg_gnt`, is high in any cycle.
- R2: One clock edge after `arb_en` is sampled low, every grant is low. Both snapshots are emptied and the next high-level capture comes before any low-level turn.
- R3: A grant never newly goes to an agent whose bit in `agent_mask` was set at the deciding edge. Bit i is for external agent i, and bit 6 is for the bridge.
- R4: If the arbiter is free and no unmasked agent is requesting, the grant goes one edge later to the bridge (`brg_gnt`=1) when `agent_mask[6]`=0, and to no agent when it is 1. A parked grant is not a tenure and can be replaced on any later edge.
- R5: While a granted tenure has not reported `tenure_done`, the grant holds unchanged.
- R6: Inside a level, the search begins at the agent after the one last granted from that level and wraps from agent 6 to agent 0. Agent indices are 0 to 5 for the external agents and 6 for the bridge.
- R7: Every agent left in the current high-level snapshot is granted before any low-level grant. Exactly one low-level grant follows, and then a new high-level snapshot is captured. A `prio_hi` bit of 1 means high level.
- R8: The low-level snapshot is recaptured from the current requests only after all of its members have been granted or have withdrawn.
- R9: If the low-level side has nothing to offer on its turn, a new high-level snapshot is captured on the same edge. If a new high-level capture is empty, a low-level agent is served on the same edge.
- R10: An agent that drops its request, or becomes masked, before its turn is removed from its snapshot and skipped.
- R11: During and after reset the grant is parked on the bridge, both snapshots are empty and both rotation pointers are at agent 0.
- R12: A decision made at a free edge shows at the grant outputs straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_en | input | 1 | Arbiter enable; low forces all grants off |
| ext_req | input | 6 | Requests from external agents 0..5 |
| brg_req | input | 1 | Request from the bridge (agent 6) |
| prio_hi | input | 7 | Per-agent level, 1 = high, bit 6 = bridge |
| agent_mask | input | 7 | Per-agent exclusion, 1 = never granted |
| tenure_done | input | 1 | Current bus tenure has finished |
| ext_gnt | output | 6 | Grants to external agents 0..5 |
| brg_gnt | output | 1 | Grant to the bridge |

## Verification
Each decision is registered once, so a grant is due one clock edge after the edge where the arbiter was free and sampled its inputs. The same one-edge latency applies to the disable and park responses. The bench changes inputs on the falling edge and advances its reference model in step with the rising edge that samples those inputs. It compares the grant outputs on the next falling edge, so the model and the design are always compared on the same decision. Directed sequences fix the expected grant order, the skipping of withdrawn requests, and the hold behaviour. Seeded random traffic covers the mixed cases.

// File: rtl/snapfair_pkg.sv
package snapfair_pkg;

  typedef enum logic [1:0] {
    PICK_NONE   = 2'd0,
    PICK_HP_OLD = 2'd1,
    PICK_HP_NEW = 2'd2,
    PICK_LP     = 2'd3
  } pick_src_e;

  // index following i on a ring of n agents
  function automatic int unsigned ring_next(int unsigned i, int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/snapfair_rr.sv
module snapfair_rr #(
  parameter int N  = 7,
  parameter int PW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [PW-1:0] ptr,
  output logic          hit,
  output logic [PW-1:0] idx
);
  // first set bit at or after ptr, wrapping
  always_comb begin
    int j;
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!hit && vec[j]) begin
        hit = 1'b1;
        idx = PW'(j);
      end
    end
  end
endmodule

// File: rtl/snapfair_sel.sv
module snapfair_sel
  import snapfair_pkg::*;
#(
  parameter int N  = 7,
  parameter int PW = $clog2(N)
) (
  input  logic [N-1:0]  hp_live,
  input  logic [N-1:0]  lp_live,
  input  logic [N-1:0]  hp_fresh,
  input  logic [N-1:0]  lp_fresh,
  input  logic          lp_turn,
  input  logic [PW-1:0] hp_ptr,
  input  logic [PW-1:0] lp_ptr,
  output logic [N-1:0]  lp_src,
  output pick_src_e     src,
  output logic [PW-1:0] win_idx
);
  logic          hit_old, hit_new, hit_lp;
  logic [PW-1:0] idx_old, idx_new, idx_lp;

  // low level keeps its snapshot until exhausted, then recaptures
  assign lp_src = (|lp_live) ? lp_live : lp_fresh;

  snapfair_rr #(.N(N), .PW(PW)) u_pick_old (.vec(hp_live),  .ptr(hp_ptr), .hit(hit_old), .idx(idx_old));
  snapfair_rr #(.N(N), .PW(PW)) u_pick_new (.vec(hp_fresh), .ptr(hp_ptr), .hit(hit_new), .idx(idx_new));
  snapfair_rr #(.N(N), .PW(PW)) u_pick_lp  (.vec(lp_src),   .ptr(lp_ptr), .hit(hit_lp),  .idx(idx_lp));

  always_comb begin
    src     = PICK_NONE;
    win_idx = '0;
    if (hit_old) begin
      src = PICK_HP_OLD; win_idx = idx_old;
    end else if (lp_turn) begin
      if (hit_lp)       begin src = PICK_LP;     win_idx = idx_lp;  end
      else if (hit_new) begin src = PICK_HP_NEW; win_idx = idx_new; end
    end else begin
      if (hit_new)      begin src = PICK_HP_NEW; win_idx = idx_new; end
      else if (hit_lp)  begin src = PICK_LP;     win_idx = idx_lp;  end
    end
  end
endmodule

// File: rtl/snapfair_arb.sv
module snapfair_arb
  import snapfair_pkg::*;
#(
  parameter int NUM_EXT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arb_en,
  input  logic [NUM_EXT-1:0] ext_req,
  input  logic               brg_req,
  input  logic [NUM_EXT:0]   prio_hi,
  input  logic [NUM_EXT:0]   agent_mask,
  input  logic               tenure_done,
  output logic [NUM_EXT-1:0] ext_gnt,
  output logic               brg_gnt
);
  localparam int NAG = NUM_EXT + 1;
  localparam int BR  = NUM_EXT;
  localparam int PW  = $clog2(NAG);

  logic [NAG-1:0] gnt_q, hp_snap, lp_snap;
  logic [PW-1:0]  hp_ptr, lp_ptr;
  logic           busy_q, lp_turn;

  // named internal events
  logic [NAG-1:0] req_eff, hp_live, lp_live, hp_fresh, lp_fresh, lp_src;
  logic [NAG-1:0] win_vec, park_vec;
  logic           free;
  pick_src_e      src;
  logic [PW-1:0]  win_idx;
  logic [PW-1:0]  next_after_win;

  assign req_eff  = {brg_req, ext_req} & ~agent_mask;
  assign hp_live  = hp_snap & req_eff;
  assign lp_live  = lp_snap & req_eff;
  assign hp_fresh = req_eff & prio_hi;
  assign lp_fresh = req_eff & ~prio_hi;
  assign free     = !busy_q || tenure_done;
  assign win_vec  = NAG'(1) << win_idx;
  assign park_vec = agent_mask[BR] ? '0 : (NAG'(1) << BR);
  assign next_after_win = PW'(ring_next(int'(win_idx), NAG));

  snapfair_sel #(.N(NAG), .PW(PW)) u_sel (
    .hp_live (hp_live),
    .lp_live (lp_live),
    .hp_fresh(hp_fresh),
    .lp_fresh(lp_fresh),
    .lp_turn (lp_turn),
    .hp_ptr  (hp_ptr),
    .lp_ptr  (lp_ptr),
    .lp_src  (lp_src),
    .src     (src),
    .win_idx (win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q   <= NAG'(1) << BR;
      busy_q  <= 1'b0;
      hp_snap <= '0;
      lp_snap <= '0;
      hp_ptr  <= '0;
      lp_ptr  <= '0;
      lp_turn <= 1'b0;
    end else if (!arb_en) begin
      gnt_q   <= '0;
      busy_q  <= 1'b0;
      hp_snap <= '0;
      lp_snap <= '0;
      lp_turn <= 1'b0;
    end else if (free) begin
      unique case (src)
        PICK_HP_OLD: begin
          hp_snap <= hp_live & ~win_vec;
          lp_snap <= lp_live;
          hp_ptr  <= next_after_win;
        end
        PICK_HP_NEW: begin
          hp_snap <= hp_fresh & ~win_vec;
          lp_snap <= lp_live;
          hp_ptr  <= next_after_win;
          lp_turn <= 1'b1;
        end
        PICK_LP: begin
          hp_snap <= '0;
          lp_snap <= lp_src & ~win_vec;
          lp_ptr  <= next_after_win;
          lp_turn <= 1'b0;
        end
        default: begin
          hp_snap <= '0;
          lp_snap <= '0;
        end
      endcase
      if (src != PICK_NONE) begin
        gnt_q  <= win_vec;
        busy_q <= 1'b1;
      end else begin
        gnt_q  <= park_vec;
        busy_q <= 1'b0;
      end
    end
  end

  assign ext_gnt = gnt_q[NUM_EXT-1:0];
  assign brg_gnt = gnt_q[BR];

  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |=> (gnt_q == '0));

  a_r3_no_masked_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gnt_q) |-> ((gnt_q & $past(agent_mask)) == '0));

  a_r4_park_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && free && req_eff == '0) |=> (gnt_q == $past(park_vec)));

  a_r5_hold_tenure: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && busy_q && !tenure_done) |=> $stable(gnt_q));

  a_r7_hp_first: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && free && hp_live != '0) |=> ((gnt_q & $past(hp_live)) != '0));
endmodule

// File: tb/snapfair_arb_test.sv
module snapfair_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       arb_en;
  logic [6:0] req_v, prio_v, mask_v;
  logic       done;
  logic [5:0] ext_gnt;
  logic       brg_gnt;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model state
  logic [6:0] m_hp, m_lp, m_gnt;
  int         m_hptr, m_lptr;
  bit         m_turn, m_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  snapfair_arb uut (
    .clk(clk), .rst_n(rst_n), .arb_en(arb_en),
    .ext_req(req_v[5:0]), .brg_req(req_v[6]),
    .prio_hi(prio_v), .agent_mask(mask_v),
    .tenure_done(done),
    .ext_gnt(ext_gnt), .brg_gnt(brg_gnt)
  );

  function automatic int ring_find(logic [6:0] v, int p);
    for (int d = 0; d < NA; d++)
      if (v[(p + d) % NA]) return (p + d) % NA;
    return -1;
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_hp = '0; m_lp = '0; m_hptr = 0; m_lptr = 0;
    m_turn = 0; m_busy = 0; m_gnt = 7'b1000000;
  endtask

  // advance the model by one rising edge using the current inputs
  task automatic model_step();
    logic [6:0] eff, hl, ll, srcv;
    int w;
    if (!arb_en) begin
      m_gnt = '0; m_busy = 0; m_hp = '0; m_lp = '0; m_turn = 0;
      return;
    end
    if (m_busy && !done) return;
    eff = req_v & ~mask_v;
    hl = m_hp & eff;
    ll = m_lp & eff;
    w = -1;
    if (hl != 0) begin
      w = ring_find(hl, m_hptr);
      m_hp = hl & ~(7'd1 << w); m_lp = ll; m_hptr = (w + 1) % NA;
    end else begin
      m_hp = '0; m_lp = ll;
      for (int pass = 0; pass < 2 && w < 0; pass++) begin
        if ((pass == 0) == m_turn) begin
          srcv = (ll != 0) ? ll : (eff & ~prio_v);
          w = ring_find(srcv, m_lptr);
          if (w >= 0) begin
            m_lp = srcv & ~(7'd1 << w); m_lptr = (w + 1) % NA; m_turn = 0;
          end
        end else begin
          srcv = eff & prio_v;
          w = ring_find(srcv, m_hptr);
          if (w >= 0) begin
            m_hp = srcv & ~(7'd1 << w); m_hptr = (w + 1) % NA; m_turn = 1;
          end
        end
      end
    end
    if (w >= 0) begin m_gnt = 7'd1 << w; m_busy = 1; end
    else begin m_gnt = mask_v[6] ? 7'd0 : 7'b1000000; m_busy = 0; end
  endtask

  task automatic cycle(string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(req, {brg_gnt, ext_gnt}, m_gnt);
    n_checks++;
    if (!$onehot0({brg_gnt, ext_gnt})) begin
      n_fail++;
      $display("FAIL R1: actual %b expected onehot0", {brg_gnt, ext_gnt});
    end
  endtask

  task automatic do_reset();
    rst_n = 0; arb_en = 1; req_v = '0; prio_v = '0; mask_v = '0; done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset park", {brg_gnt, ext_gnt}, 7'b1000000);
    rst_n = 1;
    model_reset();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [6:0] order [12];
    logic [6:0] held;
    int seed;
    seed = $urandom(32'h5eed);

    // R7 R8 R6: fixed order with HP {0,1}, LP {2,3,4}
    do_reset();
    prio_v = 7'b0000011; mask_v = 7'b1100000; req_v = 7'b0011111; done = 1;
    order = '{7'd1, 7'd2, 7'd4, 7'd1, 7'd2, 7'd8, 7'd1, 7'd2, 7'd16, 7'd1, 7'd2, 7'd4};
    foreach (order[i]) begin
      cycle("R7 order model");
      check("R7 R8 R6 order", {brg_gnt, ext_gnt}, order[i]);
    end

    // R10: withdrawn HP request skipped
    do_reset();
    prio_v = 7'b0000111; mask_v = 7'b1111000; req_v = 7'b0000111; done = 1;
    cycle("R10 first");
    check("R10 first grant", {brg_gnt, ext_gnt}, 7'b0000001);
    req_v = 7'b0000101;
    cycle("R10 skip");
    check("R10 skip withdrawn", {brg_gnt, ext_gnt}, 7'b0000100);

    // R5: hold while tenure runs; R12 grant one edge later
    done = 0; req_v = 7'b0000111;
    held = {brg_gnt, ext_gnt};
    for (int k = 0; k < 3; k++) begin
      cycle("R5 hold");
      check("R5 hold grant", {brg_gnt, ext_gnt}, held);
    end
    done = 1;
    cycle("R12 next grant after done");

    // R9: only LP requests, HP capture empty falls to LP
    do_reset();
    prio_v = 7'b0000001; mask_v = '0; req_v = 7'b0000010; done = 1;
    cycle("R9 lp served");
    check("R9 lp when hp empty", {brg_gnt, ext_gnt}, 7'b0000010);

    // R4: park and masked park
    req_v = '0;
    cycle("R4 park");
    check("R4 park bridge", {brg_gnt, ext_gnt}, 7'b1000000);
    mask_v = 7'b1000000;
    cycle("R4 masked park");
    check("R4 masked park none", {brg_gnt, ext_gnt}, 7'b0000000);

    // R2: disable
    mask_v = '0; req_v = 7'b0111111; arb_en = 0;
    cycle("R2 disabled");
    check("R2 no grant disabled", {brg_gnt, ext_gnt}, 7'b0000000);
    arb_en = 1;

    // R3 R6 R8 R10: seeded random traffic
    for (int n = 0; n < 4000; n++) begin
      req_v = 7'($urandom) & 7'($urandom | $urandom);
      done  = ($urandom % 3) == 0;
      if ($urandom % 40 == 0) prio_v = 7'($urandom);
      if ($urandom % 60 == 0) mask_v = 7'($urandom) & 7'($urandom);
      arb_en = ($urandom % 80) != 0;
      cycle("R3 R8 random");
      n_checks++;
      if ((({brg_gnt, ext_gnt} & mask_v) != 0) && m_busy && done) begin
        n_fail++;
        $display("FAIL R3: actual %b expected no masked bit %b", {brg_gnt, ext_gnt}, mask_v);
      end
    end

    finish_run();
  end
endmodule